// File: doc/BRIEF.md
# Transmit DMA Channel Control and Status Registers

This block holds the control and status state for eight transmit DMA channels. Each channel has a configuration word that sets its run mode and whether request credit is enforced. It also has a credit counter, which returns from the FIFO side raise and issued requests lower, and a buffer status word. The datapath is outside the block. It reports frame boundaries, credit returns, FIFO-full indications and scheduler activate commands as single-cycle input pulses, and the block decides from its registers which request may be issued in that cycle.

Software reaches the block through a plain write/read port: a write strobe, a byte address, write data, and read data that follows the address combinationally. Each channel owns a 0x20-byte window, with the configuration word at +0x0, the credit count at +0x4 and the buffer status at +0x8. A shared status word reports, per channel, whether the buffers are empty and whether no request is pending. A shared error word collects sticky flags that are cleared by writing ones. The channel can be paused at once, or it can be allowed to finish its current frame and then stop.

Top module: `txdma_ctl_status`

## Requirements
- R1: Channel c's configuration word is at address c*0x20. A write stores only bits 31:30, the mode (00 off, 01 stop after the current frame, 10 run, 11 treated as off), and bit 3, the credit enforcement bit. Every other bit reads 0, and a write to one channel leaves the other channels unchanged.
- R2: The credit count is at address c*0x20+0x4, with CW bits in its low bits. A write loads the count. A credit-return pulse adds one, saturating at 2^CW-1. An issued request subtracts one, but only while credit enforcement is on. A return and a counted issue in the same cycle leave the count unchanged.
- R3: A request is issued (req_issue) in the cycle it is wanted, only while the channel is running, and only if credit enforcement is off or the credit count is nonzero.
- R4: In mode 10 the channel runs, and a frame-start pulse marks it as in a frame. In mode 01 it runs only while a frame is open: a frame-end pulse stops it and a frame-start pulse opens no new frame. In mode 00 it stops in the cycle after the write, and the open frame is dropped one cycle later.
- R5: The buffer status word at address c*0x20+0x8 reads bit 0 as in-frame and bit 1 as running. All other bits read 0.
- R6: The shared status word at 0x110 reads bits 31:24 as per-channel buffers-empty (not in a frame) and bits 23:16 as per-channel no-pending (not both wanted and running). Bits 15:0 read 0. ch_idle[c] is high when both of channel c's bits are set.
- R7: Error bit c (bits 7:0) sets when channel c receives a FIFO-full pulse while its credit count is nonzero.
- R8: Error bit 9+c (bits 16:9) sets when channel c receives an activate command while its request buffer full input is high.
- R9: Error bit 31 sets on an address-error pulse and error bit 30 sets on a short-host-transfer pulse.
- R10: The error word at 0x118 is sticky. Writing 1 clears a bit and writing 0 leaves it unchanged. Bits 8 and 29:17 always read 0.
- R11: When an error event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R12: After reset, all configuration, credit and error state is 0, the shared status reads 0xFFFF0000 with no request wanted, and no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| credit_ret | input | 8 | Per-channel credit-return pulse |
| req_want | input | 8 | Per-channel request wanted by the datapath |
| req_issue | output | 8 | Per-channel request issued this cycle |
| frame_start | input | 8 | Per-channel frame-start pulse |
| frame_end | input | 8 | Per-channel frame-end pulse |
| fifo_full | input | 8 | Per-channel FIFO-full indication pulse |
| act_cmd | input | 8 | Per-channel scheduler activate command pulse |
| rbuf_full | input | 8 | Per-channel request buffer full level |
| addr_err | input | 1 | Internal memory address error pulse |
| short_xfer | input | 1 | Host sent fewer dwords than expected pulse |
| ch_idle | output | 8 | Per-channel idle (buffers empty and nothing pending) |

## Verification
The assertions check four cycle-level rules on every cycle. The credit count moves only on a return, a counted issue or a write. No request is issued against a zero count while enforcement is on. A frame opens only under run mode, and an idle channel is never mid-frame. Error bits are sticky unless cleared, and a same-cycle event always wins over the clear. The bench scenarios cover what a single-cycle property cannot see: the register map and its reserved-bit masking, the sweep of mode, enforcement, credit and want over all eight channels, and the stop-after-frame sequence across several writes and pulses. They also cover the saturating credit arithmetic and the exact bit positions of each error source.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  localparam int NCH = 8;
  localparam int AW  = 12;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_EOF = 2'b01,
    MODE_RUN = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;

  localparam logic [4:0]    SUB_CFG  = 5'h00;
  localparam logic [4:0]    SUB_CRED = 5'h04;
  localparam logic [4:0]    SUB_BUF  = 5'h08;
  localparam logic [AW-1:0] STS_ADDR = 12'h110;
  localparam logic [AW-1:0] ERR_ADDR = 12'h118;

  // defined error bits: 31, 30, 16:9, 7:0
  localparam logic [31:0] ERR_MASK = 32'hC001_FEFF;

  function automatic logic [31:0] w1c_next(input logic [31:0] cur,
                                           input logic [31:0] clr,
                                           input logic [31:0] set);
    return ((cur & ~clr) | set) & ERR_MASK;
  endfunction
endpackage

// File: rtl/txdma_chan.sv
module txdma_chan
  import txdma_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cred_we,
  input  logic [1:0]    cfg_mode_in,
  input  logic          cfg_cren_in,
  input  logic [CW-1:0] cred_in,
  input  logic          credit_ret,
  input  logic          req_want,
  input  logic          frame_start,
  input  logic          frame_end,
  input  logic          fifo_full,
  output logic          req_issue,
  output logic          running,
  output logic          in_frame,
  output logic          cren,
  output logic          mode_run,
  output logic [1:0]    mode_o,
  output logic [CW-1:0] cred,
  output logic          credit_err,
  output logic          empty,
  output logic          nopend
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  function automatic logic [CW-1:0] cred_step(input logic [CW-1:0] c,
                                              input logic up,
                                              input logic dn);
    logic [CW-1:0] r;
    r = c;
    if (up && !dn && c != CMAX) r = c + 1'b1;
    else if (dn && !up && c != '0) r = c - 1'b1;
    return r;
  endfunction

  mode_e mode_q;
  logic  cren_q, frm_q;
  logic [CW-1:0] cred_q;
  logic  is_eof, cnt_issue;

  assign mode_run  = (mode_q == MODE_RUN);
  assign is_eof    = (mode_q == MODE_EOF);
  assign running   = mode_run | (is_eof & frm_q);
  assign req_issue = req_want & running & (~cren_q | (cred_q != '0));
  assign cnt_issue = req_issue & cren_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      cren_q <= 1'b0;
      cred_q <= '0;
      frm_q  <= 1'b0;
    end else begin
      if (cfg_we) begin
        mode_q <= mode_e'(cfg_mode_in);
        cren_q <= cfg_cren_in;
      end
      if (cred_we) cred_q <= cred_in;
      else         cred_q <= cred_step(cred_q, credit_ret, cnt_issue);
      if (!(mode_run || is_eof))          frm_q <= 1'b0;
      else if (frame_start && mode_run)   frm_q <= 1'b1;
      else if (frame_end)                 frm_q <= 1'b0;
    end
  end

  assign in_frame   = frm_q;
  assign cren       = cren_q;
  assign mode_o     = mode_q;
  assign cred       = cred_q;
  assign credit_err = fifo_full & (cred_q != '0);
  assign empty      = ~frm_q;
  assign nopend     = ~(req_want & running);
endmodule

// File: rtl/txdma_err.sv
module txdma_err
  import txdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] clr_mask,
  input  logic [31:0] set_vec,
  output logic [31:0] err_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= w1c_next(err_q, clr_mask, set_vec);
  end
endmodule

// File: rtl/txdma_ctl_status.sv
module txdma_ctl_status
  import txdma_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [NCH-1:0] credit_ret,
  input  logic [NCH-1:0] req_want,
  output logic [NCH-1:0] req_issue,
  input  logic [NCH-1:0] frame_start,
  input  logic [NCH-1:0] frame_end,
  input  logic [NCH-1:0] fifo_full,
  input  logic [NCH-1:0] act_cmd,
  input  logic [NCH-1:0] rbuf_full,
  input  logic          addr_err,
  input  logic          short_xfer,
  output logic [NCH-1:0] ch_idle
);
  logic       in_ch;
  logic [2:0] ch_sel;
  logic [4:0] sub;
  assign in_ch  = (reg_addr[AW-1:8] == '0);
  assign ch_sel = reg_addr[7:5];
  assign sub    = reg_addr[4:0];

  logic [NCH-1:0] cfg_we_v, cred_we_v, cren_v, run_v, frm_v, mode_run_v;
  logic [NCH-1:0] cerr_v, empty_v, nopend_v, ovf_v;
  logic [NCH-1:0][1:0]    mode_v;
  logic [NCH-1:0][CW-1:0] cred_v;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign cfg_we_v[c]  = reg_wr & in_ch & (ch_sel == 3'(c)) & (sub == SUB_CFG);
    assign cred_we_v[c] = reg_wr & in_ch & (ch_sel == 3'(c)) & (sub == SUB_CRED);
    txdma_chan #(.CW(CW)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we_v[c]), .cred_we(cred_we_v[c]),
      .cfg_mode_in(reg_wdata[31:30]), .cfg_cren_in(reg_wdata[3]),
      .cred_in(reg_wdata[CW-1:0]),
      .credit_ret(credit_ret[c]), .req_want(req_want[c]),
      .frame_start(frame_start[c]), .frame_end(frame_end[c]),
      .fifo_full(fifo_full[c]),
      .req_issue(req_issue[c]), .running(run_v[c]), .in_frame(frm_v[c]),
      .cren(cren_v[c]), .mode_run(mode_run_v[c]), .mode_o(mode_v[c]),
      .cred(cred_v[c]), .credit_err(cerr_v[c]),
      .empty(empty_v[c]), .nopend(nopend_v[c])
    );
  end

  assign ovf_v   = act_cmd & rbuf_full;
  assign ch_idle = empty_v & nopend_v;

  logic [31:0] err_set, clr_mask, err_q;
  assign err_set  = {addr_err, short_xfer, 13'b0, ovf_v, 1'b0, cerr_v};
  assign clr_mask = (reg_wr && reg_addr == ERR_ADDR) ? reg_wdata : 32'h0;

  txdma_err u_err (
    .clk(clk), .rst_n(rst_n),
    .clr_mask(clr_mask), .set_vec(err_set), .err_q(err_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (in_ch) begin
      if (sub == SUB_CFG) begin
        reg_rdata[31:30] = mode_v[ch_sel];
        reg_rdata[3]     = cren_v[ch_sel];
      end else if (sub == SUB_CRED) begin
        reg_rdata[CW-1:0] = cred_v[ch_sel];
      end else if (sub == SUB_BUF) begin
        reg_rdata[1:0] = {run_v[ch_sel], frm_v[ch_sel]};
      end
    end else if (reg_addr == STS_ADDR) begin
      reg_rdata = {empty_v, nopend_v, 16'h0};
    end else if (reg_addr == ERR_ADDR) begin
      reg_rdata = err_q;
    end
  end
endmodule

// File: rtl/txdma_chk.sv
module txdma_chk
  import txdma_pkg::*;
#(
  parameter int CW = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         credit_ret,
  input logic [NCH-1:0]         req_issue,
  input logic [NCH-1:0]         cren_v,
  input logic [NCH-1:0]         cred_we_v,
  input logic [NCH-1:0][CW-1:0] cred_v,
  input logic [NCH-1:0]         frm_v,
  input logic [NCH-1:0]         mode_run_v,
  input logic [NCH-1:0]         ch_idle,
  input logic [31:0]            err_q,
  input logic [31:0]            err_set,
  input logic [31:0]            clr_mask
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    // R2
    cred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!credit_ret[c] && !(req_issue[c] && cren_v[c]) && !cred_we_v[c])
      |=> $stable(cred_v[c]));
    // R3
    no_credit_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_issue[c] && cren_v[c]) |-> (cred_v[c] != '0));
    // R4
    frame_open_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frm_v[c]) |-> $past(mode_run_v[c]));
    // R6
    idle_not_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_idle[c] |-> !frm_v[c]);
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(err_q) & ~$past(clr_mask)) & ~err_q) == 32'h0));
  // R11
  err_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set != 32'h0) |=> ((err_q & $past(err_set)) == $past(err_set)));
endmodule

bind txdma_ctl_status txdma_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .credit_ret(credit_ret), .req_issue(req_issue),
  .cren_v(cren_v), .cred_we_v(cred_we_v), .cred_v(cred_v), .frm_v(frm_v),
  .mode_run_v(mode_run_v), .ch_idle(ch_idle), .err_q(err_q),
  .err_set(err_set), .clr_mask(clr_mask)
);

// File: tb/sim_txdma_ctl_status.sv
module sim_txdma_ctl_status;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0] credit_ret = '0, req_want = '0, req_issue, frame_start = '0;
  logic [7:0] frame_end = '0, fifo_full = '0, act_cmd = '0, rbuf_full = '0, ch_idle;
  logic addr_err = 1'b0, short_xfer = 1'b0;
  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;

  txdma_ctl_status u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .credit_ret(credit_ret),
    .req_want(req_want), .req_issue(req_issue), .frame_start(frame_start),
    .frame_end(frame_end), .fifo_full(fifo_full), .act_cmd(act_cmd),
    .rbuf_full(rbuf_full), .addr_err(addr_err), .short_xfer(short_xfer),
    .ch_idle(ch_idle)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  function automatic logic [11:0] cadr(input int c, input int s);
    return 12'(c * 32 + s);
  endfunction

  initial begin
    #2000000;
    nerr++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R12 reset state
    req_want = 8'hFF; #1;
    chk("R12 issue", {24'h0, req_issue}, 32'h0);
    req_want = 8'h00;
    rd_chk("R12 status", 12'h110, 32'hFFFF_0000);
    rd_chk("R12 error", 12'h118, 32'h0);
    rd_chk("R12 cfg", cadr(3, 0), 32'h0);
    rd_chk("R12 credit", cadr(6, 4), 32'h0);
    chk("R12 idle", {24'h0, ch_idle}, 32'h0000_00FF);

    // R1 masking and per-channel isolation
    for (int c = 0; c < 8; c++)
      wr(cadr(c, 0), (32'(c % 4) << 30) | ((c % 2 == 1) ? 32'h8 : 32'h0) | 32'h0055_AA57);
    for (int c = 0; c < 8; c++)
      rd_chk("R1 cfg", cadr(c, 0), (32'(c % 4) << 30) | ((c % 2 == 1) ? 32'h8 : 32'h0));

    // R3 R4 R5 sweep: mode x enforcement x credit x want
    for (int c = 0; c < 8; c++)
      for (int m = 0; m < 4; m++)
        for (int e = 0; e < 2; e++)
          for (int k = 0; k < 2; k++) begin
            wr(cadr(c, 0), (32'(m) << 30) | (e == 1 ? 32'h8 : 32'h0));
            wr(cadr(c, 4), (k == 1) ? 32'h3 : 32'h0);
            for (int w = 0; w < 2; w++) begin
              req_want = (w == 1) ? (8'h1 << c) : 8'h0; #1;
              chk("R3 issue", {31'h0, req_issue[c]},
                  {31'h0, (w == 1) && (m == 2) && (e == 0 || k == 1)});
            end
            req_want = 8'h0;
            rd_chk("R5 buf", cadr(c, 8), (m == 2) ? 32'h2 : 32'h0);
            wr(cadr(c, 0), 32'h0);
          end

    // R2 credit arithmetic on channel 2
    wr(cadr(2, 0), 32'h8000_0008);
    wr(cadr(2, 4), 32'h5);
    credit_ret[2] = 1'b1; repeat (3) step(); credit_ret[2] = 1'b0;
    rd_chk("R2 returns", cadr(2, 4), 32'h8);
    req_want[2] = 1'b1; repeat (4) step(); req_want[2] = 1'b0;
    rd_chk("R2 issues", cadr(2, 4), 32'h4);
    req_want[2] = 1'b1; credit_ret[2] = 1'b1; #1;
    chk("R3 issue with credit", {31'h0, req_issue[2]}, 32'h1);
    repeat (2) step();
    req_want[2] = 1'b0; credit_ret[2] = 1'b0;
    rd_chk("R2 both", cadr(2, 4), 32'h4);
    wr(cadr(2, 4), 32'h1);
    req_want[2] = 1'b1; repeat (3) step(); #1;
    chk("R3 stall at zero", {31'h0, req_issue[2]}, 32'h0);
    req_want[2] = 1'b0;
    rd_chk("R2 floor", cadr(2, 4), 32'h0);
    wr(cadr(2, 4), 32'hFF);
    credit_ret[2] = 1'b1; step(); credit_ret[2] = 1'b0;
    rd_chk("R2 saturate", cadr(2, 4), 32'hFF);
    wr(cadr(2, 0), 32'h8000_0000);
    wr(cadr(2, 4), 32'h0);
    req_want[2] = 1'b1; #1;
    chk("R3 no enforcement", {31'h0, req_issue[2]}, 32'h1);
    repeat (2) step(); req_want[2] = 1'b0;
    rd_chk("R2 uncounted", cadr(2, 4), 32'h0);
    credit_ret[2] = 1'b1; step(); credit_ret[2] = 1'b0;
    rd_chk("R2 return unenforced", cadr(2, 4), 32'h1);

    // R4 stop-after-frame sequencing on channel 5
    wr(cadr(5, 0), 32'h8000_0000);
    frame_start[5] = 1'b1; step(); frame_start[5] = 1'b0;
    rd_chk("R4 run frame", cadr(5, 8), 32'h3);
    wr(cadr(5, 0), 32'h4000_0000);
    rd_chk("R4 eof mid-frame", cadr(5, 8), 32'h3);
    req_want[5] = 1'b1; #1;
    chk("R4 eof issues", {31'h0, req_issue[5]}, 32'h1);
    frame_end[5] = 1'b1; step(); frame_end[5] = 1'b0; #1;
    chk("R4 eof stopped", {31'h0, req_issue[5]}, 32'h0);
    rd_chk("R4 eof after end", cadr(5, 8), 32'h0);
    frame_start[5] = 1'b1; step(); frame_start[5] = 1'b0;
    rd_chk("R4 eof no new frame", cadr(5, 8), 32'h0);
    wr(cadr(5, 0), 32'h8000_0000);
    frame_start[5] = 1'b1; step(); frame_start[5] = 1'b0;
    wr(cadr(5, 0), 32'h0); #1;
    chk("R4 off immediate", {31'h0, req_issue[5]}, 32'h0);
    step();
    rd_chk("R4 off drops frame", cadr(5, 8), 32'h0);
    req_want[5] = 1'b0;
    wr(cadr(5, 0), 32'h8000_0000);
    frame_start[5] = 1'b1; step(); frame_start[5] = 1'b0;
    frame_end[5] = 1'b1; step(); frame_end[5] = 1'b0;
    rd_chk("R4 run frame end", cadr(5, 8), 32'h2);

    // R6 shared status patterns
    for (int c = 0; c < 8; c++) wr(cadr(c, 0), 32'h8000_0000);
    for (int i = 0; i < 5; i++) begin
      logic [7:0] fa, wb;
      fa = 8'(i * 8'h53);
      wb = 8'(i * 8'h29 + 1);
      frame_end = 8'hFF; step(); frame_end = 8'h0;
      frame_start = fa; step(); frame_start = 8'h0;
      req_want = wb;
      rd_chk("R6 status", 12'h110, {~fa, ~wb, 16'h0});
      chk("R6 idle", {24'h0, ch_idle}, {24'h0, ~fa & ~wb});
      req_want = 8'h0;
    end
    frame_end = 8'hFF; step(); frame_end = 8'h0;

    // R7 credit mismatch flags
    for (int c = 0; c < 8; c++) begin
      wr(cadr(c, 0), 32'h0);
      wr(cadr(c, 4), 32'(c));
    end
    fifo_full = 8'hFF; step(); fifo_full = 8'h0;
    rd_chk("R7 mismatch", 12'h118, 32'h0000_00FE);
    wr(12'h118, 32'hFFFF_FFFF);
    rd_chk("R10 clear all", 12'h118, 32'h0);

    // R8 command overflow
    act_cmd = 8'hA5; rbuf_full = 8'h0F; step(); act_cmd = 8'h0; rbuf_full = 8'h0;
    rd_chk("R8 overflow", 12'h118, 32'h0000_0A00);

    // R9 address and short transfer
    addr_err = 1'b1; step(); addr_err = 1'b0;
    rd_chk("R9 addr", 12'h118, 32'h8000_0A00);
    short_xfer = 1'b1; step(); short_xfer = 1'b0;
    rd_chk("R9 short", 12'h118, 32'hC000_0A00);

    // R10 sticky and write-one-to-clear
    wr(12'h118, 32'h0);
    rd_chk("R10 zero write", 12'h118, 32'hC000_0A00);
    wr(12'h118, 32'h4000_0200);
    rd_chk("R10 partial", 12'h118, 32'h8000_0800);
    wr(12'h118, 32'hFFFF_FFFF);
    rd_chk("R10 reserved", 12'h118, 32'h0);

    // R11 event beats clear
    fifo_full[1] = 1'b1;
    wr(12'h118, 32'h2);
    fifo_full[1] = 1'b0;
    rd_chk("R11 set wins", 12'h118, 32'h2);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule